// File: doc/BRIEF.md
# Per-Processor Device Interrupt Mask Router

This block sits between a 64-line bank of device interrupt requests and up to four processors. Each processor owns a 64-bit enable mask. A write to that mask sets which request lines may reach the processor. The block keeps, for every processor, a routed set: the lines that were both requested and enabled when the mask was last written. The request lines are captured into a shared raw request register on every clock.

When a mask write changes the routed set, the block works out which lines must be newly asserted toward the processor and which must be withdrawn. It then emits these as single-line events. Each event names the processor, the line number and whether the line is posted or cleared. A scanner walks the line indices in ascending order, one index per cycle, and holds a busy flag while the walk runs. Software-visible state is read through a combinational read port that uses the same register index space as the write port. Writes that the block cannot accept raise a one-cycle error pulse and change nothing.

Top module: `mirq_router`

## Requirements
- R1: After reset, every mask, routed and raw register reads zero; busy_o, err_o and evt_valid_o are low.
- R2: A write with index c in 0..3 while busy_o is low stores wr_data_i as the mask of processor c. That mask reads back at index c from the next cycle, and err_o stays low.
- R3: The raw register (read index 8) shows req_i one cycle later. On an accepted mask write, the routed register of processor c (read index 4+c) becomes the new mask ANDed with the raw register. It does not change when req_i changes without a mask write.
- R4: For each line whose mask bit changed and whose new routed bit is 1, exactly one event is emitted with evt_post_o=1, evt_cpu_o=c and evt_line_o=line.
- R5: For each line whose mask bit changed, whose old routed bit was 1 and whose new routed bit is 0, exactly one event is emitted with evt_post_o=0.
- R6: Lines whose mask bit did not change emit no event, even when their routed bit changes. Changed lines that meet neither R4 nor R5 also emit no event.
- R7: When a write produces at least one event, busy_o is high for exactly 64 cycles, starting the cycle after the write. The event for line k appears in the (k+1)-th busy cycle, so events come in ascending line order, at most one per cycle.
- R8: A mask write that produces no event leaves busy_o low.
- R9: A write to a routed index (4..7), to the raw index (8) or to an unused index (9..15) drives err_o high for exactly the next cycle and changes no register.
- R10: A mask write while busy_o is high is dropped, leaves the mask unchanged and drives err_o high for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 64 | Raw device interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Register index of the write |
| wr_data_i | input | 64 | Write data |
| rd_idx_i | input | 4 | Register index of the read |
| rd_data_o | output | 64 | Read data (combinational) |
| busy_o | output | 1 | Event scan in progress |
| err_o | output | 1 | One-cycle pulse after a rejected write |
| evt_valid_o | output | 1 | An event is presented this cycle |
| evt_post_o | output | 1 | 1 = post the line, 0 = clear it |
| evt_cpu_o | output | 2 | Target processor of the event |
| evt_line_o | output | 6 | Line number of the event |

## Verification
A wrong stored mask or routed set shows up at the read port in the cycle after the write. The next write to that processor would then also produce a wrong event set. A wrong pending vector or a skipped scan index shows up within the 64-cycle scan. It appears as a missing, extra or wrongly typed event at a line index whose cycle position the bench knows exactly. The bench therefore compares every scan cycle of every write, not only the final state. It includes writes injected mid-scan and directed patterns at lines 0 and 63.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

  typedef enum logic [1:0] {
    KIND_MASK,
    KIND_ROUTED,
    KIND_RAW,
    KIND_NONE
  } reg_kind_e;

  // index map: [0,n) masks, [n,2n) routed sets, 2n raw, rest unused
  function automatic reg_kind_e classify(input int idx, input int ncpu);
    if (idx < ncpu)          return KIND_MASK;
    else if (idx < 2 * ncpu) return KIND_ROUTED;
    else if (idx == 2 * ncpu) return KIND_RAW;
    else                     return KIND_NONE;
  endfunction

endpackage

// File: rtl/mirq_decode.sv
module mirq_decode
  import mirq_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int REG_IDX_W = 4,
  parameter int CPU_W     = 2
) (
  input  logic                 wr_en_i,
  input  logic [REG_IDX_W-1:0] wr_idx_i,
  input  logic                 busy_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  output logic [NUM_CPUS-1:0]  mask_we_o,
  output logic                 bad_wr_o,
  output reg_kind_e            rd_kind_o,
  output logic [CPU_W-1:0]     rd_sel_o
);

  reg_kind_e             wr_kind;
  logic [REG_IDX_W-1:0]  rd_off;

  always_comb begin
    wr_kind  = classify(int'(wr_idx_i), NUM_CPUS);
    bad_wr_o = wr_en_i && ((wr_kind != KIND_MASK) || busy_i);
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_we
    assign mask_we_o[c] = wr_en_i && !busy_i && (wr_kind == KIND_MASK) &&
                          (wr_idx_i == REG_IDX_W'(c));
  end

  always_comb begin
    rd_kind_o = classify(int'(rd_idx_i), NUM_CPUS);
    rd_off    = rd_idx_i - REG_IDX_W'(NUM_CPUS);
    rd_sel_o  = (rd_kind_o == KIND_ROUTED) ? rd_off[CPU_W-1:0] : rd_idx_i[CPU_W-1:0];
  end

endmodule

// File: rtl/mirq_bank.sv
module mirq_bank #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] routed_o,
  output logic [NUM_LINES-1:0] post_o,
  output logic [NUM_LINES-1:0] clr_o
);

  logic [NUM_LINES-1:0] mask_q, routed_q;
  logic [NUM_LINES-1:0] new_routed, changed;

  always_comb begin
    new_routed = wdata_i & raw_i;
    changed    = mask_q ^ wdata_i;
    post_o     = changed & new_routed;
    clr_o      = changed & routed_q & ~new_routed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      routed_q <= '0;
    end else if (we_i) begin
      mask_q   <= wdata_i;
      routed_q <= new_routed;
    end
  end

  assign mask_o   = mask_q;
  assign routed_o = routed_q;

endmodule

// File: rtl/mirq_scanner.sv
module mirq_scanner #(
  parameter int NUM_LINES = 64,
  parameter int CPU_W     = 2,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_LINES-1:0] post_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [CPU_W-1:0]     cpu_i,
  output logic                 busy_o,
  output logic                 evt_valid_o,
  output logic                 evt_post_o,
  output logic [CPU_W-1:0]     evt_cpu_o,
  output logic [LINE_W-1:0]    evt_line_o
);

  localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(NUM_LINES - 1);

  logic                 active_q;
  logic [LINE_W-1:0]    idx_q;
  logic [NUM_LINES-1:0] post_q, clr_q;
  logic [CPU_W-1:0]     cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      post_q   <= '0;
      clr_q    <= '0;
      cpu_q    <= '0;
    end else if (load_i && |(post_i | clr_i)) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      post_q   <= post_i;
      clr_q    <= clr_i;
      cpu_q    <= cpu_i;
    end else if (active_q) begin
      if (idx_q == LAST_IDX) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  assign busy_o      = active_q;
  assign evt_valid_o = active_q && (post_q[idx_q] || clr_q[idx_q]);
  assign evt_post_o  = active_q && post_q[idx_q];
  assign evt_cpu_o   = cpu_q;
  assign evt_line_o  = idx_q;

endmodule

// File: rtl/mirq_router.sv
module mirq_router
  import mirq_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_LINES  = 64,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int REG_IDX_W = $clog2(2 * NUM_CPUS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 wr_en_i,
  input  logic [REG_IDX_W-1:0] wr_idx_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  output logic [NUM_LINES-1:0] rd_data_o,
  output logic                 busy_o,
  output logic                 err_o,
  output logic                 evt_valid_o,
  output logic                 evt_post_o,
  output logic [CPU_W-1:0]     evt_cpu_o,
  output logic [LINE_W-1:0]    evt_line_o
);

  logic [NUM_LINES-1:0]                raw_q;
  logic                                err_q;
  logic [NUM_CPUS-1:0]                 mask_we;
  logic                                bad_wr;
  reg_kind_e                           rd_kind;
  logic [CPU_W-1:0]                    rd_sel;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_q, routed_q, post_v, clr_v;
  logic [NUM_LINES-1:0]                post_sel, clr_sel;
  logic [CPU_W-1:0]                    load_cpu;
  logic                                load;

  mirq_decode #(
    .NUM_CPUS (NUM_CPUS),
    .REG_IDX_W(REG_IDX_W),
    .CPU_W    (CPU_W)
  ) u_decode (
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .busy_i   (busy_o),
    .rd_idx_i (rd_idx_i),
    .mask_we_o(mask_we),
    .bad_wr_o (bad_wr),
    .rd_kind_o(rd_kind),
    .rd_sel_o (rd_sel)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    mirq_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (mask_we[c]),
      .wdata_i (wr_data_i),
      .raw_i   (raw_q),
      .mask_o  (mask_q[c]),
      .routed_o(routed_q[c]),
      .post_o  (post_v[c]),
      .clr_o   (clr_v[c])
    );
  end

  // one-hot select of the written bank
  always_comb begin
    post_sel = '0;
    clr_sel  = '0;
    load_cpu = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (mask_we[c]) begin
        post_sel = post_v[c];
        clr_sel  = clr_v[c];
        load_cpu = CPU_W'(c);
      end
    end
    load = |mask_we;
  end

  mirq_scanner #(
    .NUM_LINES(NUM_LINES),
    .CPU_W    (CPU_W)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .post_i     (post_sel),
    .clr_i      (clr_sel),
    .cpu_i      (load_cpu),
    .busy_o     (busy_o),
    .evt_valid_o(evt_valid_o),
    .evt_post_o (evt_post_o),
    .evt_cpu_o  (evt_cpu_o),
    .evt_line_o (evt_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      err_q <= 1'b0;
    end else begin
      raw_q <= req_i;
      err_q <= bad_wr;
    end
  end

  assign err_o = err_q;

  always_comb begin
    unique case (rd_kind)
      KIND_MASK:   rd_data_o = mask_q[rd_sel];
      KIND_ROUTED: rd_data_o = routed_q[rd_sel];
      KIND_RAW:    rd_data_o = raw_q;
      default:     rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/mirq_router_chk.sv
module mirq_router_chk #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_LINES  = 64,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int REG_IDX_W = $clog2(2 * NUM_CPUS + 1)
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                wr_en_i,
  input logic [REG_IDX_W-1:0]                wr_idx_i,
  input logic                                busy_o,
  input logic                                err_o,
  input logic                                evt_valid_o,
  input logic                                evt_post_o,
  input logic [CPU_W-1:0]                    evt_cpu_o,
  input logic [LINE_W-1:0]                   evt_line_o,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_q,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0]  routed_q
);

  AST_ERR_BAD_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (int'(wr_idx_i) >= NUM_CPUS) |=> err_o); // R9
  AST_BAD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ((int'(wr_idx_i) >= NUM_CPUS) || busy_o) |=> $stable(mask_q) && $stable(routed_q)); // R9
  AST_ERR_BUSY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && busy_o |=> err_o); // R10
  AST_NO_ERR_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !busy_o && (int'(wr_idx_i) < NUM_CPUS) |=> !err_o); // R2
  AST_EVT_IN_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> busy_o); // R7
  AST_LINE_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && $past(evt_valid_o) |-> evt_line_o > $past(evt_line_o)); // R7
  AST_POST_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && evt_post_o |-> routed_q[evt_cpu_o][evt_line_o]); // R4
  AST_CLR_UNROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && !evt_post_o |-> !routed_q[evt_cpu_o][evt_line_o]); // R5

endmodule

bind mirq_router mirq_router_chk #(
  .NUM_CPUS (NUM_CPUS),
  .NUM_LINES(NUM_LINES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .evt_valid_o(evt_valid_o),
  .evt_post_o (evt_post_o),
  .evt_cpu_o  (evt_cpu_o),
  .evt_line_o (evt_line_o),
  .mask_q     (mask_q),
  .routed_q   (routed_q)
);

// File: tb/tb_mirq_router.sv
`timescale 1ns/1ps
module tb_mirq_router;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        busy_o, err_o, evt_valid_o, evt_post_o;
  logic [1:0]  evt_cpu_o;
  logic [5:0]  evt_line_o;

  always #2 clk_i = ~clk_i;

  mirq_router dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_routed [4];
  logic [63:0] m_raw;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rand64();
    return {$urandom, $urandom};
  endfunction

  task automatic rd_chk(input int idx, input logic [63:0] exp, input string req);
    rd_idx_i = 4'(idx);
    #0.3;
    chk(rd_data_o === exp, req, $sformatf("read idx %0d", idx), rd_data_o, exp);
  endtask

  task automatic all_regs_chk(input string req);
    for (int c = 0; c < 4; c++) begin
      rd_chk(c, m_mask[c], req);
      rd_chk(4 + c, m_routed[c], req);
    end
    rd_chk(8, m_raw, req);
  endtask

  task automatic set_req(input logic [63:0] v);
    @(negedge clk_i);
    req_i = v;
    @(negedge clk_i);
    m_raw = v;
    rd_chk(8, v, "R3");
  endtask

  task automatic mask_write(input int cpu, input logic [63:0] d, input bit inject);
    logic [63:0] nr, ch, ep, ec;
    bit any, ev;
    int mism;
    string info;
    nr  = d & m_raw;
    ch  = m_mask[cpu] ^ d;
    ep  = ch & nr;
    ec  = ch & m_routed[cpu] & ~nr;
    any = |(ep | ec);
    mism = 0;
    info = "";
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 4'(cpu); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(err_o == 1'b0, "R2", "err after mask write", 64'(err_o), 64'd0);
    for (int i = 0; i < 64; i++) begin
      if (i > 0) @(negedge clk_i);
      ev = any && (ep[i] || ec[i]);
      if (busy_o !== any) begin
        mism++;
        if (info == "") info = $sformatf("busy cyc %0d got %0b exp %0b", i, busy_o, any);
      end
      if (evt_valid_o !== ev) begin
        mism++;
        if (info == "") info = $sformatf("valid line %0d got %0b exp %0b", i, evt_valid_o, ev);
      end else if (ev && (evt_post_o !== ep[i] || evt_cpu_o !== 2'(cpu) || evt_line_o !== 6'(i))) begin
        mism++;
        if (info == "") info = $sformatf("evt line %0d got post %0b cpu %0d line %0d exp post %0b cpu %0d",
                                         i, evt_post_o, evt_cpu_o, evt_line_o, ep[i], cpu);
      end
      if (inject && any && i == 10) begin
        wr_en_i = 1'b1; wr_idx_i = 4'(cpu); wr_data_i = ~d;
      end
      if (inject && any && i == 11) begin
        wr_en_i = 1'b0;
        chk(err_o == 1'b1, "R10", "err after busy write", 64'(err_o), 64'd1);
      end
    end
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R7", "busy after scan", 64'(busy_o), 64'd0);
    n_tests++;
    if (mism != 0) begin
      n_fail++;
      $display("FAIL R4 R5 R6 R7 R8 cpu %0d: %s (mismatches got %0d expected 0)", cpu, info, mism);
    end
    m_mask[cpu]   = d;
    m_routed[cpu] = nr;
    rd_chk(cpu, d, inject ? "R10" : "R2");
    rd_chk(4 + cpu, nr, "R3");
  endtask

  task automatic bad_write(input int idx, input logic [63:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(err_o == 1'b1, "R9", $sformatf("err after write idx %0d", idx), 64'(err_o), 64'd1);
    @(negedge clk_i);
    chk(err_o == 1'b0, "R9", "err one cycle only", 64'(err_o), 64'd0);
    chk(busy_o == 1'b0, "R9", "no scan from bad write", 64'(busy_o), 64'd0);
    all_regs_chk("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 4; c++) begin m_mask[c] = '0; m_routed[c] = '0; end
    m_raw = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(busy_o == 1'b0, "R1", "busy", 64'(busy_o), 0);
    chk(err_o == 1'b0, "R1", "err", 64'(err_o), 0);
    chk(evt_valid_o == 1'b0, "R1", "evt_valid", 64'(evt_valid_o), 0);
    all_regs_chk("R1");

    // boundary lines 0 and 63
    set_req('1);
    mask_write(1, 64'h8000_0000_0000_0001, 1'b0);
    mask_write(1, 64'h0, 1'b0);

    // R6/R8: mask changes but nothing requested
    set_req('0);
    mask_write(2, 64'h0000_0000_0000_FFFF, 1'b0);
    // R3: raw changes alone do not touch routed
    set_req(64'h0000_0000_0000_00FF);
    rd_chk(6, 64'h0, "R3");
    // R6: same mask rewritten, routed updates, no events
    mask_write(2, 64'h0000_0000_0000_FFFF, 1'b0);
    // R6: changed lines without requests, no events
    mask_write(2, 64'h0000_0000_00FF_00FF, 1'b0);
    // R5: clear from routed lines
    mask_write(2, 64'h0000_0000_00FF_0000, 1'b0);

    // R10: write during scan
    set_req(rand64());
    mask_write(3, rand64() | 64'h1, 1'b1);

    // R9: illegal indices
    bad_write(4, rand64());
    bad_write(7, rand64());
    bad_write(8, rand64());
    bad_write(12, rand64());
    bad_write(15, rand64());

    // random mix
    for (int n = 0; n < 40; n++) begin
      int cpu;
      logic [63:0] d;
      cpu = int'($urandom % 4);
      if ($urandom % 3 == 0) set_req(rand64());
      if ($urandom % 2 == 0) d = m_mask[cpu] ^ (rand64() & rand64() & rand64());
      else                   d = rand64();
      mask_write(cpu, d, ($urandom % 5) == 0);
    end
    all_regs_chk("R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule